// File: doc/BRIEF.md
# Six-Channel Serial Audio Receiver

This block recovers multi-channel audio from a serial bus. One bit clock and one word-select line are shared by three serial data lines, and each data line carries a stereo pair. The block acts as the receiving end: its clock input is the bit clock itself, and data and word select are both sampled on its rising edge. A single framing engine tracks the word-select transitions and tells three identical lane slices when each half-frame starts and which bit position is arriving. Each lane assembles its left and right words. When the right word of a frame is complete, all six words are published together and a one-cycle strobe marks the new frame.

Three framings are supported. The first is I2S, where the MSB follows the word-select change by one bit. The second is MSB-justified, where the MSB arrives with the change. The third is LSB-justified at 16, 18, 20 or 24 bits, where the LSB is the last bit before the next change. The framing is chosen in one of two ways: a 3-bit register-style code, or, when the strap-select input is high, a 2-bit pin-strap code. Every word is delivered left-aligned in a signed 24-bit field.

Top module: `serial_audio_rx`

## Requirements
- R1: I2S framing (register code 000): the MSB is the bit sampled one bit clock after a word-select transition. Word select low marks the left channel. At most 24 bits are taken; later bits of the half-frame are ignored, and a half-frame shorter than 24 bits leaves the missing low bits zero.
- R2: MSB-justified framing (register code 100): the MSB is the bit sampled in the same cycle that word select changes. Word select high marks the left channel. Bits past the 24th are ignored, and unsent low bits read as zero.
- R3: LSB-justified framing with word length W: the word is the last W bits sampled before the next word-select transition. Word select high marks the left channel. The word is placed in bits 23 down to 24-W of the output, with zeros below.
- R4: With strap_en low, fmt_code selects the framing: 000 I2S, 001 LSB-justified 16, 010 LSB-justified 18, 011 LSB-justified 20, 100 MSB-justified, 101 LSB-justified 24.
- R5: With strap_en high, strap_code selects the framing and fmt_code has no effect: 00 I2S, 01 LSB-justified 16, 10 LSB-justified 20, 11 LSB-justified 24.
- R6: Register codes 110 and 111 are reserved. While one of them is selected, no frame strobe is issued and samples_o holds its value.
- R7: Serial line k (k = 0, 1, 2) carries channels 2k+1 (left) and 2k+2 (right). Channel n appears at samples_o[(n-1)*24 +: 24], and all six channels are taken from the same frame.
- R8: frame_valid_o is high for exactly one cycle per frame, after the right half-frame has ended. A strobe is issued only when a complete left half and a complete right half have been received since reset; the partial half-frame in progress at reset is discarded. samples_o changes only in the cycle in which frame_valid_o is high.
- R9: During and after reset, samples_o is all zeros and frame_valid_o is low.
- R10: Half-frames of any length up to 32 bit clocks (64 bit clocks per frame) are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; data and word select sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ws | input | 1 | Word select shared by all data lines |
| sdata | input | 3 | Serial data, one bit per line (line 0 = channels 1/2) |
| strap_en | input | 1 | High: use strap_code; low: use fmt_code |
| fmt_code | input | 3 | Register-style framing code |
| strap_code | input | 2 | Pin-strap framing code |
| samples_o | output | 144 | Six 24-bit words, channel 1 in the lowest field |
| frame_valid_o | output | 1 | One-cycle strobe when a new frame is published |

## Verification
The hardest case to reach is the I2S alignment. There, the framing edge is seen one bit after the word-select change, so the engine must not confuse the last bit of one word with the first bit of the next. A wrong history level at reset also yields a spurious half-frame. To reach these cases, the stimulus builds one bit stream per frame and, for I2S, drives word select one bit ahead of it. Random half-frame lengths from short (zero-fill) to 32 bits (discarded tail) are mixed with every code of both tables. Reserved codes are applied without a reset in between, so that held outputs are visible at the ports.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   typedef enum logic [1:0] {
      FK_I2S  = 2'd0,
      FK_MSBJ = 2'd1,
      FK_LSBJ = 2'd2,
      FK_NONE = 2'd3
   } fmt_kind_e;

   localparam int LSBW_BITS = 5;

   typedef struct packed {
      fmt_kind_e              kind;
      logic [LSBW_BITS-1:0]   lsb_w;
   } fmt_sel_t;

   function automatic fmt_sel_t mk_fmt(fmt_kind_e k, int w);
      fmt_sel_t f;
      f.kind  = k;
      f.lsb_w = LSBW_BITS'(w);
      return f;
   endfunction

endpackage

// File: rtl/sarx_fmt_decode.sv
module sarx_fmt_decode
   import sarx_pkg::*;
(
   input  logic       strap_en,
   input  logic [2:0] fmt_code,
   input  logic [1:0] strap_code,
   output fmt_sel_t   sel
);

   always_comb begin
      sel = mk_fmt(FK_NONE, 0);
      if (strap_en) begin
         unique case (strap_code)
            2'b00: sel = mk_fmt(FK_I2S, 0);
            2'b01: sel = mk_fmt(FK_LSBJ, 16);
            2'b10: sel = mk_fmt(FK_LSBJ, 20);
            2'b11: sel = mk_fmt(FK_LSBJ, 24);
            default: sel = mk_fmt(FK_NONE, 0);
         endcase
      end else begin
         unique case (fmt_code)
            3'b000: sel = mk_fmt(FK_I2S, 0);
            3'b001: sel = mk_fmt(FK_LSBJ, 16);
            3'b010: sel = mk_fmt(FK_LSBJ, 18);
            3'b011: sel = mk_fmt(FK_LSBJ, 20);
            3'b100: sel = mk_fmt(FK_MSBJ, 0);
            3'b101: sel = mk_fmt(FK_LSBJ, 24);
            default: sel = mk_fmt(FK_NONE, 0);
         endcase
      end
   end

endmodule

// File: rtl/sarx_frame_ctrl.sv
module sarx_frame_ctrl
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int HALF_MAX = 32,
   localparam int CNT_W   = $clog2(HALF_MAX) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ws,
   input  fmt_kind_e        kind,
   output logic             first_bit_o,
   output logic [CNT_W-1:0] idx_o,
   output logic             cap_left_o,
   output logic             cap_right_o,
   output logic             frame_valid_o
);

   logic             ws_q, ws_qq;
   logic [1:0]       hist;
   logic             seen, left_ok;
   logic [CNT_W-1:0] cnt;
   logic             is_i2s, fmt_ok;
   logic             eff_ws, eff_prev, first;

   assign is_i2s = (kind == FK_I2S);
   assign fmt_ok = (kind != FK_NONE);

   // I2S: word select leads the MSB by one bit, so use the delayed copy
   assign eff_ws   = is_i2s ? ~ws_q  : ws;
   assign eff_prev = is_i2s ? ~ws_qq : ws_q;
   assign first    = (eff_ws ^ eff_prev) & hist[1];

   assign first_bit_o = first;
   assign idx_o       = first ? '0 : cnt;
   assign cap_left_o  = first & seen & eff_prev & fmt_ok;
   assign cap_right_o = first & seen & ~eff_prev & fmt_ok & left_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_q          <= 1'b0;
         ws_qq         <= 1'b0;
         hist          <= '0;
         seen          <= 1'b0;
         left_ok       <= 1'b0;
         cnt           <= '0;
         frame_valid_o <= 1'b0;
      end else begin
         ws_q  <= ws;
         ws_qq <= ws_q;
         hist  <= {hist[0], 1'b1};
         if (first) begin
            seen <= 1'b1;
            cnt  <= CNT_W'(1);
         end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
         end
         if (cap_left_o)
            left_ok <= 1'b1;
         else if (first && !eff_prev)
            left_ok <= 1'b0;
         frame_valid_o <= cap_right_o;
      end
   end

   // R8
   fv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o);

   // R6
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_NONE) |=> !frame_valid_o);

endmodule

// File: rtl/sarx_lane.sv
module sarx_lane
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int HALF_MAX = 32,
   localparam int CNT_W   = $clog2(HALF_MAX) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sd,
   input  logic                 first_bit,
   input  logic [CNT_W-1:0]     idx,
   input  fmt_kind_e            kind,
   input  logic [LSBW_BITS-1:0] lsb_w,
   input  logic                 cap_left,
   input  logic                 cap_right,
   output logic [SAMPLE_W-1:0]  left_o,
   output logic [SAMPLE_W-1:0]  right_o
);

   logic [SAMPLE_W-1:0] shreg;
   logic [SAMPLE_W-1:0] acc;
   logic [SAMPLE_W-1:0] left_stage;
   logic [SAMPLE_W-1:0] word;

   // right-aligned word: last lsb_w bits before the edge, moved to the top
   always_comb begin
      if (kind == FK_LSBJ)
         word = shreg << (SAMPLE_W - int'(lsb_w));
      else
         word = acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg      <= '0;
         acc        <= '0;
         left_stage <= '0;
         left_o     <= '0;
         right_o    <= '0;
      end else begin
         shreg <= {shreg[SAMPLE_W-2:0], sd};
         if (first_bit) begin
            acc <= {sd, {(SAMPLE_W-1){1'b0}}};
         end else begin
            for (int k = 0; k < SAMPLE_W; k++) begin
               if (int'(idx) == SAMPLE_W - 1 - k)
                  acc[k] <= sd;
            end
         end
         if (cap_left)
            left_stage <= word;
         if (cap_right) begin
            left_o  <= left_stage;
            right_o <= word;
         end
      end
   end

   // R3
   lsb16_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_right && kind == FK_LSBJ && lsb_w == LSBW_BITS'(16))
         |=> (right_o[SAMPLE_W-17:0] == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sarx_pkg::*;
#(
   parameter int NUM_LINES = 3,
   parameter int SAMPLE_W  = 24,
   parameter int HALF_MAX  = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ws,
   input  logic [NUM_LINES-1:0]            sdata,
   input  logic                            strap_en,
   input  logic [2:0]                      fmt_code,
   input  logic [1:0]                      strap_code,
   output logic [NUM_LINES*2*SAMPLE_W-1:0] samples_o,
   output logic                            frame_valid_o
);

   localparam int CNT_W = $clog2(HALF_MAX) + 1;

   generate
      if (SAMPLE_W < 24) begin : g_chk_width
         $error("serial_audio_rx: SAMPLE_W must hold a 24-bit word");
      end
      if (HALF_MAX < SAMPLE_W) begin : g_chk_half
         $error("serial_audio_rx: HALF_MAX must be at least SAMPLE_W");
      end
      if (NUM_LINES < 1) begin : g_chk_lines
         $error("serial_audio_rx: NUM_LINES must be positive");
      end
   endgenerate

   fmt_sel_t          sel;
   logic              first_bit;
   logic [CNT_W-1:0]  idx;
   logic              cap_left, cap_right;

   sarx_fmt_decode u_decode (
      .strap_en   (strap_en),
      .fmt_code   (fmt_code),
      .strap_code (strap_code),
      .sel        (sel)
   );

   sarx_frame_ctrl #(
      .SAMPLE_W (SAMPLE_W),
      .HALF_MAX (HALF_MAX)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ws            (ws),
      .kind          (sel.kind),
      .first_bit_o   (first_bit),
      .idx_o         (idx),
      .cap_left_o    (cap_left),
      .cap_right_o   (cap_right),
      .frame_valid_o (frame_valid_o)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      sarx_lane #(
         .SAMPLE_W (SAMPLE_W),
         .HALF_MAX (HALF_MAX)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .sd        (sdata[l]),
         .first_bit (first_bit),
         .idx       (idx),
         .kind      (sel.kind),
         .lsb_w     (sel.lsb_w),
         .cap_left  (cap_left),
         .cap_right (cap_right),
         .left_o    (samples_o[(2*l)*SAMPLE_W +: SAMPLE_W]),
         .right_o   (samples_o[(2*l+1)*SAMPLE_W +: SAMPLE_W])
      );
   end

   // R8
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid_o |-> $stable(samples_o));

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

   localparam int NL = 3;
   localparam int SW = 24;
   localparam int TW = NL * 2 * SW;
   localparam int K_I2S = 0, K_MSB = 1, K_LSB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ws = 1'b0;
   logic [NL-1:0] sdata = '0;
   logic          strap_en = 1'b0;
   logic [2:0]    fmt_code = 3'b000;
   logic [1:0]    strap_code = 2'b00;
   logic [TW-1:0] samples;
   logic          fv;

   always #4 clk = ~clk;

   serial_audio_rx u_serial_audio_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .ws            (ws),
      .sdata         (sdata),
      .strap_en      (strap_en),
      .fmt_code      (fmt_code),
      .strap_code    (strap_code),
      .samples_o     (samples),
      .frame_valid_o (fv)
   );

   int            checks = 0;
   int            errors = 0;
   bit            ws_seq [0:4095];
   logic [NL-1:0] d_seq  [0:4095];
   int            nseq;
   logic [TW-1:0] exp_q [$];
   string         cur_req = "R9";
   bit            expect_on;
   int            fv_cnt;
   int            hold_bad;
   logic          fv_prev = 1'b0;
   logic [TW-1:0] last_samples = '0;

   // output monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (fv) begin
            fv_cnt++;
            checks++;
            if (fv_prev) begin
               errors++;
               $display("FAIL R8 strobe longer than one cycle: got 1 exp 0");
            end
            if (exp_q.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R8 (%s) unexpected strobe: got 1 exp 0", cur_req);
            end else begin
               logic [TW-1:0] e;
               e = exp_q.pop_front();
               for (int c = 0; c < 2*NL; c++) begin
                  checks++;
                  if (samples[c*SW +: SW] !== e[c*SW +: SW]) begin
                     errors++;
                     $display("FAIL %s R7 ch%0d: got %h exp %h", cur_req, c+1,
                              samples[c*SW +: SW], e[c*SW +: SW]);
                  end
               end
            end
         end else if (samples !== last_samples) begin
            hold_bad++;
         end
      end
      fv_prev      = fv;
      last_samples = samples;
   end

   task automatic push_bit(bit w, logic [NL-1:0] d);
      ws_seq[nseq] = w;
      d_seq[nseq]  = d;
      nseq++;
   endtask

   task automatic add_frame(int kind, int wl, int h);
      logic [TW-1:0] s;
      logic [TW-1:0] e;
      for (int c = 0; c < 2*NL; c++) s[c*SW +: SW] = SW'($urandom);
      for (int half = 0; half < 2; half++) begin
         for (int i = 0; i < h; i++) begin
            logic [NL-1:0] dv;
            for (int l = 0; l < NL; l++) begin
               logic [SW-1:0] x;
               x = s[(2*l+half)*SW +: SW];
               if (kind == K_LSB)
                  dv[l] = (i >= h - wl) ? x[h-1-i] : 1'($urandom);
               else
                  dv[l] = (i < SW) ? x[SW-1-i] : 1'($urandom);
            end
            push_bit(half == 0, dv);
         end
      end
      for (int c = 0; c < 2*NL; c++) begin
         logic [SW-1:0] x;
         logic [SW-1:0] t;
         x = s[c*SW +: SW];
         if (kind == K_LSB)      t = x << (SW - wl);
         else if (h >= SW)       t = x;
         else                    t = (x >> (SW - h)) << (SW - h);
         e[c*SW +: SW] = t;
      end
      if (expect_on) exp_q.push_back(e);
   endtask

   task automatic do_reset(int kind);
      rst_n = 1'b0;
      ws    = (kind == K_I2S) ? 1'b1 : 1'b0;
      sdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_q.delete();
   endtask

   task automatic run_fmt(int kind, int wl, int h, int nfr, string req, bit expect_frames);
      int exp_n;
      cur_req   = req;
      expect_on = expect_frames;
      nseq      = 0;
      repeat (5) push_bit(1'b0, NL'($urandom));
      for (int f = 0; f < nfr; f++) add_frame(kind, wl, h);
      repeat (4) push_bit(1'b1, NL'($urandom));
      exp_n    = exp_q.size();
      fv_cnt   = 0;
      hold_bad = 0;
      for (int t = 0; t < nseq; t++) begin
         @(negedge clk);
         if (kind == K_I2S) ws = ~ws_seq[(t + 1 < nseq) ? t + 1 : t];
         else               ws = ws_seq[t];
         sdata = d_seq[t];
      end
      repeat (12) @(negedge clk);
      checks++;
      if (fv_cnt != exp_n) begin
         errors++;
         $display("FAIL R8 (%s) strobe count: got %0d exp %0d", req, fv_cnt, exp_n);
      end
      checks++;
      if (hold_bad != 0) begin
         errors++;
         $display("FAIL R8 (%s) outputs moved without strobe: got %0d exp 0", req, hold_bad);
      end
      exp_q.delete();
   endtask

   task automatic reg_run(logic [2:0] code, int h, string req);
      int kind, wl;
      case (code)
         3'b000: begin kind = K_I2S; wl = 0;  end
         3'b001: begin kind = K_LSB; wl = 16; end
         3'b010: begin kind = K_LSB; wl = 18; end
         3'b011: begin kind = K_LSB; wl = 20; end
         3'b100: begin kind = K_MSB; wl = 0;  end
         default: begin kind = K_LSB; wl = 24; end
      endcase
      if (h < wl) h = wl;
      strap_en = 1'b0;
      fmt_code = code;
      do_reset(kind);
      run_fmt(kind, wl, h, 3, req, 1'b1);
   endtask

   task automatic strap_run(logic [1:0] code, int h);
      int kind, wl;
      case (code)
         2'b00: begin kind = K_I2S; wl = 0;  end
         2'b01: begin kind = K_LSB; wl = 16; end
         2'b10: begin kind = K_LSB; wl = 20; end
         default: begin kind = K_LSB; wl = 24; end
      endcase
      if (h < wl) h = wl;
      strap_en   = 1'b1;
      strap_code = code;
      fmt_code   = 3'b110;
      do_reset(kind);
      run_fmt(kind, wl, h, 3, "R5", 1'b1);
   endtask

   task automatic reserved_run(logic [2:0] code);
      logic [TW-1:0] snap;
      snap     = samples;
      strap_en = 1'b0;
      fmt_code = code;
      run_fmt(K_MSB, 0, 32, 3, "R6", 1'b0);
      checks++;
      if (samples !== snap) begin
         errors++;
         $display("FAIL R6 outputs changed under code %b: got %h exp %h", code, samples, snap);
      end
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      do_reset(K_MSB);
      // R9 reset state
      checks++;
      if (samples !== '0 || fv !== 1'b0) begin
         errors++;
         $display("FAIL R9 reset state: got %h/%b exp 0/0", samples, fv);
      end

      // R2 full 32-bit slots and short slots with zero fill
      reg_run(3'b100, 32, "R2 R10");
      reg_run(3'b100, 24, "R2");
      reg_run(3'b100, 13, "R2");
      // R1 I2S at several slot lengths
      reg_run(3'b000, 24, "R1");
      reg_run(3'b000, 32, "R1 R10");
      reg_run(3'b000, 10, "R1");
      // R3 / R4 right-aligned words, exact fit and padded slot
      reg_run(3'b001, 16, "R3 R4");
      reg_run(3'b010, 32, "R3 R4");
      reg_run(3'b011, 20, "R3 R4");
      reg_run(3'b101, 32, "R3 R4 R10");
      reg_run(3'b101, 24, "R3 R4");

      // R6 reserved codes after a good run, without reset
      reserved_run(3'b110);
      reserved_run(3'b111);

      // R5 strap table with a reserved register code present
      strap_run(2'b00, 32);
      strap_run(2'b01, 16);
      strap_run(2'b10, 25);
      strap_run(2'b11, 32);

      // random mix over the register table
      for (int r = 0; r < 14; r++) begin
         logic [2:0] code;
         code = 3'($urandom_range(0, 5));
         reg_run(code, $urandom_range(4, 32), "R4 rnd");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule